// File: doc/BRIEF.md
# Clock-Control Register Slave on a Two-Wire Serial Bus

This block is a two-wire serial (I2C) target that holds a small bank of 8-bit clock-control registers for a clock generator. A bus controller writes the bank as one sequential block and can read it back. The block never drives SCL. It watches SCL and SDA through a synchronizer running on a fast system clock, and it drives SDA only by pulling it low, for acknowledges and for read data bits that are 0.

A write carries the target address, then two bytes the block acknowledges but does not use (a command byte and a count byte), and then data bytes. The first data byte goes to register 0 and each later one goes to the next register. A read has no pointer. It always streams register 0 first, then the registers that follow, until the controller answers a byte with a NACK.

The whole bank is presented as a flat parallel bus. The fields of register 0 are also decoded onto their own ports, for the clock-generation logic next to the block.

Top module: `clkctl_i2c_slave`

## Requirements
- R1: An asynchronous reset, treated as the only true power-up, loads the registers with these values: reg0 = 0x00, reg1 = 0xFF, reg2 = 0x7F, reg3 = 0xFF, reg4 = 0x0F, reg5 = 0x13, reg6 = 0x00. A bit set to 1 in reg1..reg5 means that clock runs.
- R2: The block responds only to the 7-bit address 1101001, which puts 0xD2 on the wire for a write and 0xD3 for a read. For any other address byte it gives no ACK, and it keeps SDA released until the next START or STOP, data bytes included.
- R3: In a write, the block ACKs the command byte and the count byte that follow the address and ignores their values. Data bytes then go to reg0, reg1 and onward in order, MSB first. Every such byte is ACKed, and a register changes only when a received data byte completes.
- R4: In a write, data bytes that arrive after reg6 are ACKed and discarded.
- R5: In a read, the block ACKs 0xD3 and then sends reg0, reg1 and onward, MSB first. It pulls SDA low for each 0 bit and releases it for each 1 bit.
- R6: In a read, every byte after reg6 reads as 0xFF.
- R7: When the controller NACKs a read byte, the block releases SDA and does not drive it again until a new START.
- R8: Every START, including a repeated START, returns the byte index to the beginning, so the next data byte goes to reg0.
- R9: After a STOP the block is idle and SDA is released.
- R10: The register 0 fields appear on their own ports. Bit 0 is out_hiz (tri-state all clock outputs), bit 1 is ss_enable, bit 2 is ss_down (1 = down spread, 0 = center spread), bit 3 is sw_sel (1 = software frequency select), bits 6:4 are sw_code, and bit 7 is ss_half (1 = 0.5 % spread, 0 = 1.5 %).
- R11: The block starts pulling SDA low only while SCL is low. It never begins to pull SDA low after SCL has been high for five or more system clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| scl_i | input | 1 | Bus clock line as received |
| sda_i | input | 1 | Bus data line as received (wired-AND level) |
| sda_oe | output | 1 | 1 = pull SDA low, 0 = release |
| reg_flat | output | NUM_REGS*8 | Register n on bits [8n+7:8n] |
| out_hiz | output | 1 | reg0 bit 0: tri-state all clock outputs |
| ss_enable | output | 1 | reg0 bit 1: spread spectrum on |
| ss_down | output | 1 | reg0 bit 2: down spread when 1, center spread when 0 |
| sw_sel | output | 1 | reg0 bit 3: frequency chosen by software code |
| sw_code | output | 3 | reg0 bits 6:4: software frequency code |
| ss_half | output | 1 | reg0 bit 7: 0.5 % spread when 1, 1.5 % when 0 |

## Verification
Four block writes are each followed by a full read-back. Their data are all zeros, all ones, and two arithmetic patterns, so a stuck bit, a swapped bit order or an index that is off by one shows up as a mismatch in a known register. Every block write and read runs two bytes past the end of the bank, which separates correct discarding and 0xFF fill from wrap-around or overwriting of the last register. Mismatched addresses (one of them differs only in its lowest address bit), an early NACK followed by extra clocking, and a repeated START partway through a write show whether the block keeps off the bus and restarts its index as required.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK,
      ST_SKIP
   } slv_state_t;

   // power-up value of each control register; enable bits set to 1
   function automatic logic [7:0] reg_default(input int idx);
      case (idx)
         1:       return 8'hFF;
         2:       return 8'h7F;
         3:       return 8'hFF;
         4:       return 8'h0F;
         5:       return 8'h13;
         default: return 8'h00;
      endcase
   endfunction

endpackage

// File: rtl/clkctl_line_sync.sv
module clkctl_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("clkctl_line_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= 1'b1;
            else if (s == 0) chain[s] <= line_i;
            else chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b1;
      else prev <= chain[STAGES-1];
   end

   assign level_o = chain[STAGES-1];
   assign rise_o  = chain[STAGES-1] & ~prev;
   assign fall_o  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/clkctl_regbank.sv
module clkctl_regbank #(
   parameter int NUM_REGS = 7,
   parameter int IDX_W    = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [IDX_W-1:0]      wr_idx,
   input  logic [7:0]            wr_data,
   input  logic [IDX_W-1:0]      rd_idx,
   output logic [7:0]            rd_data,
   output logic [NUM_REGS*8-1:0] flat_o
);
   import clkctl_pkg::*;

   logic [7:0] regs_q [NUM_REGS];

   generate
      for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[g] <= reg_default(g);
            else if (wr_en && wr_idx == IDX_W'(g)) regs_q[g] <= wr_data;
         end
         assign flat_o[g*8 +: 8] = regs_q[g];
      end
   endgenerate

   // indices past the bank read as all ones
   always_comb begin
      rd_data = 8'hFF;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_idx == IDX_W'(i)) rd_data = regs_q[i];
      end
   end
endmodule

// File: rtl/clkctl_i2c_slave.sv
module clkctl_i2c_slave #(
   parameter int         NUM_REGS    = 7,
   parameter logic [6:0] DEV_ADDR    = 7'b1101001,
   parameter int         SYNC_STAGES = 2,
   parameter int         SKIP_BYTES  = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe,
   output logic [NUM_REGS*8-1:0] reg_flat,
   output logic                  out_hiz,
   output logic                  ss_enable,
   output logic                  ss_down,
   output logic                  sw_sel,
   output logic [2:0]            sw_code,
   output logic                  ss_half
);
   import clkctl_pkg::*;

   localparam int IDX_W = $clog2(NUM_REGS + SKIP_BYTES + 1) + 1;
   localparam logic [IDX_W-1:0] IDX_MAX = '1;

   generate
      if (NUM_REGS < 1 || NUM_REGS > 16) begin : g_bad_regs
         $error("clkctl_i2c_slave: NUM_REGS out of range");
      end
   endgenerate

   logic scl_s, scl_rise, scl_fall;
   logic sda_s, sda_rise, sda_fall;

   clkctl_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .line_i(scl_i),
      .level_o(scl_s), .rise_o(scl_rise), .fall_o(scl_fall));

   clkctl_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .line_i(sda_i),
      .level_o(sda_s), .rise_o(sda_rise), .fall_o(sda_fall));

   wire start_ev = scl_s & ~scl_rise & sda_fall;
   wire stop_ev  = scl_s & ~scl_rise & sda_rise;

   slv_state_t       state;
   logic [3:0]       bit_cnt;
   logic [7:0]       rx_sh;
   logic [7:0]       tx_sh;
   logic [IDX_W-1:0] byte_no;
   logic             is_addr;
   logic             rd_mode;
   logic             nack;

   logic             wr_en;
   logic [IDX_W-1:0] wr_idx;
   logic [7:0]       rd_data;

   wire byte_done = (state == ST_RX) && scl_fall && (bit_cnt == 4'd8);
   wire [IDX_W-1:0] byte_inc = (byte_no == IDX_MAX) ? byte_no : byte_no + 1'b1;

   assign wr_en  = byte_done && !is_addr && !rd_mode && !start_ev && !stop_ev
                   && (byte_no >= IDX_W'(SKIP_BYTES));
   assign wr_idx = byte_no - IDX_W'(SKIP_BYTES);

   clkctl_regbank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(rx_sh),
      .rd_idx(byte_no), .rd_data(rd_data), .flat_o(reg_flat));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         bit_cnt <= '0;
         rx_sh   <= '0;
         tx_sh   <= '0;
         byte_no <= '0;
         is_addr <= 1'b0;
         rd_mode <= 1'b0;
         nack    <= 1'b0;
         sda_oe  <= 1'b0;
      end else if (start_ev) begin
         state   <= ST_RX;
         bit_cnt <= '0;
         byte_no <= '0;
         is_addr <= 1'b1;
         rd_mode <= 1'b0;
         sda_oe  <= 1'b0;
      end else if (stop_ev) begin
         state  <= ST_IDLE;
         sda_oe <= 1'b0;
      end else begin
         case (state)
            ST_RX: begin
               if (scl_rise) begin
                  rx_sh   <= {rx_sh[6:0], sda_s};
                  bit_cnt <= bit_cnt + 4'd1;
               end else if (byte_done) begin
                  if (is_addr && rx_sh[7:1] != DEV_ADDR) begin
                     state <= ST_SKIP;
                  end else begin
                     state  <= ST_ACK;
                     sda_oe <= 1'b1;
                     if (is_addr) rd_mode <= rx_sh[0];
                  end
               end
            end
            ST_ACK: begin
               if (scl_fall) begin
                  bit_cnt <= '0;
                  is_addr <= 1'b0;
                  if (rd_mode) begin
                     state  <= ST_TX;
                     tx_sh  <= rd_data;
                     sda_oe <= ~rd_data[7];
                  end else begin
                     state  <= ST_RX;
                     sda_oe <= 1'b0;
                     if (!is_addr) byte_no <= byte_inc;
                  end
               end
            end
            ST_TX: begin
               if (scl_fall) begin
                  if (bit_cnt == 4'd7) begin
                     state  <= ST_MACK;
                     sda_oe <= 1'b0;
                  end else begin
                     tx_sh   <= {tx_sh[6:0], 1'b1};
                     sda_oe  <= ~tx_sh[6];
                     bit_cnt <= bit_cnt + 4'd1;
                  end
               end
            end
            ST_MACK: begin
               if (scl_rise) begin
                  nack <= sda_s;
                  if (!sda_s) byte_no <= byte_inc;
               end else if (scl_fall) begin
                  bit_cnt <= '0;
                  if (nack) begin
                     state <= ST_SKIP;
                  end else begin
                     state  <= ST_TX;
                     tx_sh  <= rd_data;
                     sda_oe <= ~rd_data[7];
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign out_hiz   = reg_flat[0];
   assign ss_enable = reg_flat[1];
   assign ss_down   = reg_flat[2];
   assign sw_sel    = reg_flat[3];
   assign sw_code   = reg_flat[6:4];
   assign ss_half   = reg_flat[7];
endmodule

// File: rtl/clkctl_i2c_checker.sv
module clkctl_i2c_checker #(
   parameter int NUM_REGS = 7
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     scl_i,
   input logic                     sda_oe,
   input clkctl_pkg::slv_state_t   state,
   input logic [3:0]               bit_cnt,
   input logic [NUM_REGS*8-1:0]    reg_flat
);
   import clkctl_pkg::*;

   // R11: pull-down never begins once SCL has been high a while
   assert_no_drive_scl_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3)
       && $past(scl_i, 4) && $past(scl_i, 5)) |-> !$rose(sda_oe));

   // R9: idle block keeps off the bus
   assert_idle_released_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);

   // R2 / R7: skipped transfer keeps off the bus
   assert_skip_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SKIP) |-> !sda_oe);

   // R7: leaving the controller-ACK slot into skip releases SDA
   assert_nack_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(state) == ST_MACK && state == ST_SKIP) |-> !sda_oe);

   // R3: registers change only as a received byte completes
   assert_reg_change_in_rx_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(reg_flat) |-> ($past(state) == ST_RX && $past(bit_cnt) == 4'd8));

   // R5: bit counter stays inside one byte plus the completion slot
   assert_bitcnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= 4'd8);
endmodule

bind clkctl_i2c_slave clkctl_i2c_checker #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
   .state(state), .bit_cnt(bit_cnt), .reg_flat(reg_flat));

// File: tb/tb_clkctl_i2c_slave.sv
module tb_clkctl_i2c_slave;
   localparam int NR = 7;
   localparam int Q  = 8;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, scl_m, sda_m;
   logic sda_oe;
   wire  sda_line = sda_m & ~sda_oe;
   logic [NR*8-1:0] reg_flat;
   logic out_hiz, ss_enable, ss_down, sw_sel, ss_half;
   logic [2:0] sw_code;

   clkctl_i2c_slave dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .reg_flat(reg_flat), .out_hiz(out_hiz),
      .ss_enable(ss_enable), .ss_down(ss_down), .sw_sel(sw_sel),
      .sw_code(sw_code), .ss_half(ss_half));

   int n_chk = 0, n_fail = 0;
   int scl_hi_run = 0, r11_viol = 0;
   logic prev_oe = 1'b0;
   logic [7:0] model [NR];

   task automatic check(input bit ok, input string tag,
                        input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic hq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq();
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
      end
      sda_m = 1'b1; hq(); scl_m = 1'b1; hq();
      acked = !sda_line;
      hq(); scl_m = 1'b0; hq();
   endtask

   task automatic recv_byte(input bit give_ack, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         hq(); scl_m = 1'b1; hq(); b[i] = sda_line; hq(); scl_m = 1'b0;
      end
      hq(); sda_m = give_ack ? 1'b0 : 1'b1;
      hq(); scl_m = 1'b1; hq(); hq(); scl_m = 1'b0; hq();
      sda_m = 1'b1;
   endtask

   function automatic logic [7:0] pat(input int p, input int i);
      if (p == 0) return 8'h00;
      if (p == 1) return 8'hFF;
      return 8'(p * 53 + i * 29) ^ 8'hA5;
   endfunction

   task automatic check_bank(input string tag);
      for (int i = 0; i < NR; i++)
         check(reg_flat[i*8 +: 8] == model[i], tag, reg_flat[i*8 +: 8], model[i]);
   endtask

   // R11 monitor: a new pull-down must not begin deep inside an SCL high phase
   always @(negedge clk) begin
      if (rst_n) begin
         if (sda_oe && !prev_oe && scl_hi_run >= 6) r11_viol++;
      end
      prev_oe    <= sda_oe;
      scl_hi_run <= scl_m ? scl_hi_run + 1 : 0;
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      bit ack;
      logic [7:0] rb;
      logic [7:0] v;
      rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
      repeat (5) @(negedge clk);
      // R1: power-up values
      for (int i = 0; i < NR; i++) model[i] = clkctl_pkg::reg_default(i);
      check(reg_flat == {8'h00, 8'h13, 8'h0F, 8'hFF, 8'h7F, 8'hFF, 8'h00},
            "R1 reset bank", reg_flat, {8'h00, 8'h13, 8'h0F, 8'hFF, 8'h7F, 8'hFF, 8'h00});
      check(sda_oe == 1'b0, "R1 reset sda", sda_oe, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      for (int p = 0; p < 4; p++) begin
         bus_start();
         send_byte(8'hD2, ack); check(ack, "R2 write address ack", ack, 1);
         send_byte(8'(p * 17 + 3), ack); check(ack, "R3 command ack", ack, 1);
         send_byte(8'h5C, ack); check(ack, "R3 count ack", ack, 1);
         for (int i = 0; i < NR + 2; i++) begin
            v = pat(p, i);
            send_byte(v, ack);
            if (i < NR) begin
               model[i] = v;
               check(ack, "R3 data ack", ack, 1);
            end else begin
               check(ack, "R4 overflow ack", ack, 1);
            end
         end
         bus_stop();
         hq();
         check_bank("R3/R4 bank after write");
         check(sda_oe == 1'b0, "R9 released after stop", sda_oe, 0);
         check({ss_half, sw_code, sw_sel, ss_down, ss_enable, out_hiz} == model[0],
               "R10 field ports", {ss_half, sw_code, sw_sel, ss_down, ss_enable, out_hiz}, model[0]);

         bus_start();
         send_byte(8'hD3, ack); check(ack, "R5 read address ack", ack, 1);
         for (int i = 0; i < NR + 2; i++) begin
            recv_byte(i < NR + 1, rb);
            if (i < NR) check(rb == model[i], "R5 read data", rb, model[i]);
            else check(rb == 8'hFF, "R6 read past end", rb, 8'hFF);
         end
         bus_stop();
         hq();
      end

      // R10: a known field pattern 1011_0101
      bus_start();
      send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
      send_byte(8'hB5, ack); model[0] = 8'hB5;
      bus_stop(); hq();
      check(out_hiz == 1'b1 && ss_enable == 1'b0 && ss_down == 1'b1 && sw_sel == 1'b0
            && sw_code == 3'b011 && ss_half == 1'b1, "R10 decode B5",
            {ss_half, sw_code, sw_sel, ss_down, ss_enable, out_hiz}, 8'hB5);

      // R7: early NACK, then extra clocks must see SDA released
      bus_start();
      send_byte(8'hD3, ack); check(ack, "R7 read address ack", ack, 1);
      recv_byte(1'b1, rb); check(rb == model[0], "R7 first byte", rb, model[0]);
      recv_byte(1'b0, rb); check(rb == model[1], "R7 nacked byte", rb, model[1]);
      begin
         int low_seen = 0;
         for (int k = 0; k < 9; k++) begin
            hq(); scl_m = 1'b1; hq();
            if (!sda_line) low_seen++;
            hq(); scl_m = 1'b0; hq();
         end
         check(low_seen == 0, "R7 released after nack", low_seen, 0);
      end
      bus_stop(); hq();

      // R2: foreign addresses get no ACK and change nothing
      bus_start();
      send_byte(8'hA4, ack); check(!ack, "R2 foreign address nack", ack, 0);
      send_byte(8'h00, ack); check(!ack, "R2 no ack after mismatch", ack, 0);
      send_byte(8'h00, ack); send_byte(8'h00, ack);
      check(!ack, "R2 data byte ignored", ack, 0);
      bus_stop(); hq();
      bus_start();
      send_byte(8'hD0, ack); check(!ack, "R2 near address nack", ack, 0);
      bus_stop(); hq();
      check_bank("R2 bank unchanged");

      // R8: repeated START returns to reg0
      bus_start();
      send_byte(8'hD2, ack); send_byte(8'h01, ack); send_byte(8'h02, ack);
      send_byte(8'h11, ack); send_byte(8'h22, ack);
      bus_start();
      send_byte(8'hD2, ack); check(ack, "R8 address after restart", ack, 1);
      send_byte(8'h01, ack); send_byte(8'h01, ack);
      send_byte(8'h3C, ack); check(ack, "R8 data ack", ack, 1);
      bus_stop(); hq();
      model[0] = 8'h3C; model[1] = 8'h22;
      check_bank("R8 index restart");

      check(r11_viol == 0, "R11 drive begins with SCL low", r11_viol, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule